// File: doc/BRIEF.md
# Precise Pipeline Trap Controller

This block is the trap control for a five-stage in-order pipeline. It watches two fault sources: an illegal-opcode flag raised by the decode stage and an arithmetic-overflow flag raised by the execute stage. Each source comes with a valid bit and with the PC of the instruction in that stage. When a fault is accepted, the block does four things on the next clock edge:

- It pulses flush strobes for the fetch, decode and execute pipeline registers.
- It pulses a write-kill strobe for an overflowing instruction, which has moved on to the memory stage by then.
- It redirects the PC to a handler.
- It records the trap PC plus four and a one-bit cause code.

Traps stay precise. Instructions older than the faulting one are left alone. When both stages fault in the same cycle, the older instruction in execute is the one taken. A mode pin chooses between a single fixed handler entry and cause-indexed entries spaced 0x20 apart.

Handler software reads and writes the saved PC and cause through a small select/data port. Whenever the two collide, hardware trap capture has priority over a software write.

Top module: `precise_trap_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `redirect`, `flush_if`, `flush_id`, `flush_ex` and `wr_block` are 0, and both saved registers read 0.
- R2: An overflow with `ex_valid`=1 in cycle N makes `redirect`, all three flush strobes and `wr_block` equal 1 in cycle N+1. From N+1 on, the saved PC (`cp_sel`=0) reads `ex_pc`+4 and the cause (`cp_sel`=1) reads 1.
- R3: An illegal opcode with `id_valid`=1 and no execute fault in cycle N makes `redirect` and all three flush strobes equal 1 in cycle N+1, with `wr_block`=0. The saved PC reads `id_pc`+4 and the cause reads 0.
- R4: When both stages fault in the same cycle, only the execute fault is recorded (cause 1, saved PC `ex_pc`+4), and a single redirect results.
- R5: With `vec_mode`=0 in the detection cycle, `redirect_pc` is 0x8000_0180 for either cause.
- R6: With `vec_mode`=1, `redirect_pc` is 0xC000_0000 + cause×0x20: 0xC000_0000 for an illegal opcode and 0xC000_0020 for an overflow.
- R7: A fault flag whose stage valid bit is 0 has no effect. No redirect follows and the saved registers keep their values.
- R8: Fault flags present in a cycle where `redirect` is 1 belong to flushed instructions and are ignored. The strobes return to 0 and the saved registers keep their values.
- R9: Every strobe (`redirect`, the flushes, `wr_block`) is high for exactly one cycle per accepted trap, and stays low when no fault is accepted.
- R10: With no trap accepted, `cp_we`=1 writes `cp_wdata` at the edge: the saved PC when `cp_sel`=0, or the cause (bit 0 of the data) when `cp_sel`=1. `cp_rdata` shows the selected register combinationally, with the cause zero-extended.
- R11: A trap accepted in the same cycle as a software write wins. The saved PC and cause take the trap values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vec_mode | input | 1 | 1 selects cause-indexed handler entries |
| id_valid | input | 1 | Decode stage holds a live instruction |
| id_bad_op | input | 1 | Decode stage opcode is illegal |
| id_pc | input | 32 | PC of the decode-stage instruction |
| ex_valid | input | 1 | Execute stage holds a live instruction |
| ex_ovf | input | 1 | Execute stage arithmetic overflow |
| ex_pc | input | 32 | PC of the execute-stage instruction |
| cp_sel | input | 1 | Register select: 0 saved PC, 1 cause |
| cp_we | input | 1 | Software write enable |
| cp_wdata | input | 32 | Software write data |
| cp_rdata | output | 32 | Selected register contents |
| redirect | output | 1 | One-cycle PC redirect strobe |
| redirect_pc | output | 32 | Handler entry address, valid with `redirect` |
| flush_if | output | 1 | Squash the fetch-stage register |
| flush_id | output | 1 | Squash the decode-stage register |
| flush_ex | output | 1 | Squash the execute-stage register |
| wr_block | output | 1 | Kill the register write of the overflowing instruction |

## Verification
An execute-stage overflow and a decode-stage illegal opcode can arrive in the same cycle. Trap capture and a software write to the saved registers can also meet at one edge. The bench sets both fault flags together, in both handler modes, and checks that the cause reads 1, that the saved PC is the execute PC plus four, and that `wr_block` is raised. It also combines a trap with a software write and checks that the trap values land. Random traffic with a fixed seed mixes valid bits, fault flags and software writes, and a cycle-level model computed from the requirements judges every cycle.

// File: rtl/trap_pkg.sv
package trap_pkg;
  // Cause codes: the handler decodes these values.
  localparam int CAUSE_UNDEF = 0;
  localparam int CAUSE_OVF   = 1;
  // Register select codes on the software port.
  localparam logic SEL_EPC   = 1'b0;
  localparam logic SEL_CAUSE = 1'b1;
  // Fault source order, oldest stage first.
  localparam int SRC_EX  = 0;
  localparam int SRC_ID  = 1;
  localparam int NUM_SRC = 2;
endpackage

// File: rtl/trap_pick.sv
module trap_pick #(
  parameter int NSRC = 2,
  parameter int AW   = 32,
  parameter int CW   = 1
) (
  input  logic [NSRC-1:0]    hit,
  input  logic [NSRC*AW-1:0] pc_flat,
  input  logic [NSRC*CW-1:0] code_flat,
  output logic               any_hit,
  output logic [NSRC-1:0]    win,
  output logic [AW-1:0]      sel_pc,
  output logic [CW-1:0]      sel_code
);
  logic [NSRC:0] older_clear;

  assign older_clear[0] = 1'b1;

  // Index 0 is the oldest stage: a hit there masks all younger ones.
  for (genvar g = 0; g < NSRC; g++) begin : g_chain
    assign older_clear[g+1] = older_clear[g] & ~hit[g];
    assign win[g]           = hit[g] & older_clear[g];
  end

  assign any_hit = |hit;

  always_comb begin
    sel_pc   = '0;
    sel_code = '0;
    for (int i = 0; i < NSRC; i++) begin
      sel_pc   = sel_pc   | ({AW{win[i]}} & pc_flat[i*AW +: AW]);
      sel_code = sel_code | ({CW{win[i]}} & code_flat[i*CW +: CW]);
    end
  end
endmodule

// File: rtl/trap_vector.sv
module trap_vector #(
  parameter int          AW       = 32,
  parameter int          CW       = 1,
  parameter logic [31:0] FIXED    = 32'h8000_0180,
  parameter logic [31:0] VBASE    = 32'hC000_0000,
  parameter int          STEP_LG2 = 5
) (
  input  logic          vec_mode,
  input  logic [CW-1:0] code,
  output logic [AW-1:0] target
);
  localparam logic [AW-1:0] FIXED_A = AW'(FIXED);
  localparam logic [AW-1:0] VBASE_A = AW'(VBASE);

  logic [AW-1:0] offset;

  assign offset = AW'(code) << STEP_LG2;
  assign target = vec_mode ? (VBASE_A + offset) : FIXED_A;
endmodule

// File: rtl/trap_csr.sv
module trap_csr #(
  parameter int AW = 32,
  parameter int CW = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [AW-1:0] take_pc,
  input  logic [CW-1:0] take_code,
  input  logic          sw_we,
  input  logic          sw_sel,
  input  logic [AW-1:0] sw_data,
  output logic [AW-1:0] epc_q,
  output logic [CW-1:0] cause_q
);
  import trap_pkg::*;

  logic [AW-1:0] epc_next;

  // Saved PC points one word past the trapping instruction.
  assign epc_next = take_pc + AW'(4);

  always_ff @(posedge clk) begin
    if (rst) begin
      epc_q   <= '0;
      cause_q <= '0;
    end else if (take) begin
      epc_q   <= epc_next;
      cause_q <= take_code;
    end else if (sw_we) begin
      if (sw_sel == SEL_EPC) epc_q   <= sw_data;
      else                   cause_q <= sw_data[CW-1:0];
    end
  end

  // R11
  trap_over_sw_chk: assert property (@(posedge clk) disable iff (rst)
    (take && sw_we) |=> (epc_q == $past(take_pc) + AW'(4)));

  // R10
  sw_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!take && sw_we && sw_sel == SEL_EPC) |=> (epc_q == $past(sw_data)));
endmodule

// File: rtl/precise_trap_unit.sv
module precise_trap_unit #(
  parameter int          AW       = 32,
  parameter int          CW       = 1,
  parameter logic [31:0] FIXED    = 32'h8000_0180,
  parameter logic [31:0] VBASE    = 32'hC000_0000,
  parameter int          STEP_LG2 = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vec_mode,
  input  logic          id_valid,
  input  logic          id_bad_op,
  input  logic [AW-1:0] id_pc,
  input  logic          ex_valid,
  input  logic          ex_ovf,
  input  logic [AW-1:0] ex_pc,
  input  logic          cp_sel,
  input  logic          cp_we,
  input  logic [AW-1:0] cp_wdata,
  output logic [AW-1:0] cp_rdata,
  output logic          redirect,
  output logic [AW-1:0] redirect_pc,
  output logic          flush_if,
  output logic          flush_id,
  output logic          flush_ex,
  output logic          wr_block
);
  import trap_pkg::*;

  localparam int NS = NUM_SRC;

  logic [NS-1:0]    hit;
  logic [NS-1:0]    win;
  logic [NS*AW-1:0] pc_flat;
  logic [NS*CW-1:0] code_flat;
  logic             take;
  logic [AW-1:0]    sel_pc;
  logic [CW-1:0]    sel_code;
  logic [AW-1:0]    target;
  logic [AW-1:0]    epc_q;
  logic [CW-1:0]    cause_q;

  // Flags that arrive while a redirect is out belong to squashed instructions.
  assign hit[SRC_EX] = ex_valid & ex_ovf    & ~redirect;
  assign hit[SRC_ID] = id_valid & id_bad_op & ~redirect;

  assign pc_flat   = {id_pc, ex_pc};
  assign code_flat = {CW'(CAUSE_UNDEF), CW'(CAUSE_OVF)};

  trap_pick #(.NSRC(NS), .AW(AW), .CW(CW)) u_pick (
    .hit      (hit),
    .pc_flat  (pc_flat),
    .code_flat(code_flat),
    .any_hit  (take),
    .win      (win),
    .sel_pc   (sel_pc),
    .sel_code (sel_code)
  );

  trap_vector #(.AW(AW), .CW(CW), .FIXED(FIXED), .VBASE(VBASE),
                .STEP_LG2(STEP_LG2)) u_vec (
    .vec_mode(vec_mode),
    .code    (sel_code),
    .target  (target)
  );

  trap_csr #(.AW(AW), .CW(CW)) u_csr (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .take_pc  (sel_pc),
    .take_code(sel_code),
    .sw_we    (cp_we),
    .sw_sel   (cp_sel),
    .sw_data  (cp_wdata),
    .epc_q    (epc_q),
    .cause_q  (cause_q)
  );

  // Registered strobes. The faulting instruction and every younger one have
  // moved one stage on when these rise, so all three front registers are cut.
  always_ff @(posedge clk) begin
    if (rst) begin
      redirect    <= 1'b0;
      redirect_pc <= '0;
      flush_if    <= 1'b0;
      flush_id    <= 1'b0;
      flush_ex    <= 1'b0;
      wr_block    <= 1'b0;
    end else begin
      redirect <= take;
      flush_if <= take;
      flush_id <= take;
      flush_ex <= take;
      wr_block <= win[SRC_EX];
      if (take) redirect_pc <= target;
    end
  end

  assign cp_rdata = (cp_sel == SEL_CAUSE) ? {{(AW-CW){1'b0}}, cause_q} : epc_q;

  // R2
  ovf_take_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(ex_valid && ex_ovf && !redirect))
      |-> (redirect && wr_block && flush_ex && cause_q == CW'(CAUSE_OVF)));

  // R3
  undef_no_block_chk: assert property (@(posedge clk) disable iff (rst)
    (redirect && !wr_block) |-> (cause_q == CW'(CAUSE_UNDEF)));

  // R4
  oldest_wins_chk: assert property (@(posedge clk) disable iff (rst)
    hit[SRC_EX] |-> (win[SRC_EX] && !win[SRC_ID] && $onehot0(win)));

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    redirect |=> !redirect);

  // R7
  needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && redirect)
      |-> $past((ex_valid && ex_ovf) || (id_valid && id_bad_op)));
endmodule

// File: tb/precise_trap_unit_test.sv
module precise_trap_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vec_mode = 1'b0;
  logic        id_valid = 1'b0, id_bad_op = 1'b0;
  logic [31:0] id_pc = '0;
  logic        ex_valid = 1'b0, ex_ovf = 1'b0;
  logic [31:0] ex_pc = '0;
  logic        cp_sel = 1'b0, cp_we = 1'b0;
  logic [31:0] cp_wdata = '0;
  logic [31:0] cp_rdata, redirect_pc;
  logic        redirect, flush_if, flush_id, flush_ex, wr_block;

  int nchecks = 0;
  int nfail   = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  precise_trap_unit uut (
    .clk(clk), .rst(rst), .vec_mode(vec_mode),
    .id_valid(id_valid), .id_bad_op(id_bad_op), .id_pc(id_pc),
    .ex_valid(ex_valid), .ex_ovf(ex_ovf), .ex_pc(ex_pc),
    .cp_sel(cp_sel), .cp_we(cp_we), .cp_wdata(cp_wdata), .cp_rdata(cp_rdata),
    .redirect(redirect), .redirect_pc(redirect_pc),
    .flush_if(flush_if), .flush_id(flush_id), .flush_ex(flush_ex),
    .wr_block(wr_block)
  );

  // Expected-state model built from the requirements.
  logic        m_redir = 1'b0, m_wb = 1'b0, m_cause = 1'b0;
  logic [31:0] m_pc = '0, m_epc = '0;

  function automatic logic [31:0] entry(input logic vm, input logic c);
    return vm ? (32'hC000_0000 + (c ? 32'h20 : 32'h0)) : 32'h8000_0180;
  endfunction

  always @(posedge clk) begin
    logic tex, tid;
    if (rst) begin
      m_redir = 0; m_wb = 0; m_cause = 0; m_pc = 0; m_epc = 0;
    end else begin
      tex = !m_redir && ex_valid && ex_ovf;
      tid = !m_redir && !tex && id_valid && id_bad_op;
      m_redir = tex || tid;
      m_wb    = tex;
      if (tex || tid) begin
        m_cause = tex;
        m_epc   = (tex ? ex_pc : id_pc) + 32'd4;
        m_pc    = entry(vec_mode, tex);
      end else if (cp_we) begin
        if (cp_sel) m_cause = cp_wdata[0];
        else        m_epc   = cp_wdata;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " redirect"}, {31'b0, redirect}, {31'b0, m_redir});
    chk({tag, " flush_if"}, {31'b0, flush_if}, {31'b0, m_redir});
    chk({tag, " flush_id"}, {31'b0, flush_id}, {31'b0, m_redir});
    chk({tag, " flush_ex"}, {31'b0, flush_ex}, {31'b0, m_redir});
    chk({tag, " wr_block"}, {31'b0, wr_block}, {31'b0, m_wb});
    if (m_redir) chk({tag, " redirect_pc"}, redirect_pc, m_pc);
    chk({tag, " rdata"}, cp_rdata, cp_sel ? {31'b0, m_cause} : m_epc);
  endtask

  task automatic tick(input string tag);
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic quiet();
    id_valid = 0; id_bad_op = 0; ex_valid = 0; ex_ovf = 0; cp_we = 0;
  endtask

  task automatic read_sel(input logic s, output logic [31:0] v);
    cp_sel = s; #1; v = cp_rdata;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2468));

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 redirect", {31'b0, redirect}, 0);
    chk("R1 wr_block", {31'b0, wr_block}, 0);
    chk("R1 flushes", {29'b0, flush_if, flush_id, flush_ex}, 0);
    rst = 0;
    tick("R1");
    read_sel(1, v); chk("R1 cause", v, 0);
    read_sel(0, v); chk("R1 epc", v, 0);

    // R2 + R5: overflow alone, fixed entry
    vec_mode = 0; ex_valid = 1; ex_ovf = 1; ex_pc = 32'h50;
    tick("R2");
    chk("R2 epc", cp_rdata, 32'h54);
    chk("R2 wr_block", {31'b0, wr_block}, 1);
    chk("R5 redirect_pc", redirect_pc, 32'h8000_0180);
    read_sel(1, v); chk("R2 cause", v, 1);
    quiet(); cp_sel = 0;
    tick("R9");
    chk("R9 redirect low", {31'b0, redirect}, 0);

    // R3 + R6: illegal opcode alone, vectored
    vec_mode = 1; id_valid = 1; id_bad_op = 1; id_pc = 32'h1000;
    tick("R3");
    chk("R3 wr_block", {31'b0, wr_block}, 0);
    chk("R3 epc", cp_rdata, 32'h1004);
    chk("R6 redirect_pc", redirect_pc, 32'hC000_0000);
    read_sel(1, v); chk("R3 cause", v, 0);
    quiet(); cp_sel = 0;
    tick("R9");

    // R4: both stages at once, vectored then fixed
    for (int m = 1; m >= 0; m--) begin
      vec_mode = m[0];
      ex_valid = 1; ex_ovf = 1; ex_pc = 32'h200;
      id_valid = 1; id_bad_op = 1; id_pc = 32'h204;
      tick("R4");
      chk("R4 epc", cp_rdata, 32'h204);
      chk("R4 wr_block", {31'b0, wr_block}, 1);
      chk(m ? "R6 redirect_pc" : "R5 redirect_pc", redirect_pc,
          m ? 32'hC000_0020 : 32'h8000_0180);
      read_sel(1, v); chk("R4 cause", v, 1);
      quiet(); cp_sel = 0;
      tick("R4");
    end

    // R7: flags without valid
    ex_ovf = 1; id_bad_op = 1; ex_pc = 32'h900; id_pc = 32'h904;
    tick("R7");
    chk("R7 redirect", {31'b0, redirect}, 0);
    tick("R7");
    chk("R7 epc", cp_rdata, 32'h204);
    quiet();

    // R8: fault held into the redirect cycle
    vec_mode = 0; ex_valid = 1; ex_ovf = 1; ex_pc = 32'h300;
    tick("R8");
    chk("R8 first epc", cp_rdata, 32'h304);
    ex_pc = 32'h400; id_valid = 1; id_bad_op = 1;
    tick("R8");
    chk("R8 redirect", {31'b0, redirect}, 0);
    chk("R8 epc", cp_rdata, 32'h304);
    quiet();
    tick("R8");

    // R10: software writes
    cp_we = 1; cp_sel = 0; cp_wdata = 32'hABCD_0000;
    tick("R10");
    chk("R10 epc", cp_rdata, 32'hABCD_0000);
    cp_sel = 1; cp_wdata = 32'hFFFF_FFFF;
    tick("R10");
    chk("R10 cause", cp_rdata, 32'h1);
    cp_wdata = 32'h0;
    tick("R10");
    chk("R10 cause clr", cp_rdata, 32'h0);

    // R11: trap against software write
    cp_sel = 0; cp_wdata = 32'h1234_5678; id_valid = 1; id_bad_op = 1; id_pc = 32'h600;
    tick("R11");
    chk("R11 epc", cp_rdata, 32'h604);
    quiet();
    tick("R11");

    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      vec_mode  = $urandom_range(0, 1) == 1;
      ex_valid  = $urandom_range(0, 3) != 0;
      ex_ovf    = $urandom_range(0, 5) == 0;
      id_valid  = $urandom_range(0, 3) != 0;
      id_bad_op = $urandom_range(0, 5) == 0;
      ex_pc     = $urandom() & 32'hFFFF_FFFC;
      id_pc     = $urandom() & 32'hFFFF_FFFC;
      cp_we     = $urandom_range(0, 4) == 0;
      cp_sel    = $urandom_range(0, 1) == 1;
      cp_wdata  = $urandom();
      tick("R9 random");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end
endmodule